// File: doc/BRIEF.md
# Shared System Bus Controller

This block sits between two bus masters and two slave modules on one shared bus: a 128-word memory and an I/O module. A master raises its request line and presents a command (read or write), an 8-bit address and write data. The controller grants the bus to one master at a time. It latches that master's command and splits the address. The top address bit picks the target module and the seven low bits become the word or port offset inside it. The controller then raises exactly one of four strobes: memory read, memory write, I/O read or I/O write.

The strobe stays up until the addressed module returns its acknowledge. The controller then pulses a done line to the owning master, returns the read data, and drops the grant one cycle later. If no acknowledge arrives within a bounded number of cycles, the transfer ends with an error flag. Only the granted master's write data ever reaches the shared data lines, which are modelled as a multiplexer output.

Top module: `sysbus_ctrl`

## Requirements
- R1: While reset is low at a clock edge, all grants, all four strobes and both done lines are low after that edge.
- R2: An address with bit 7 clear targets memory and uses a memory strobe. An address with bit 7 set targets I/O and uses an I/O strobe. In both cases the offset output equals address bits 6..0.
- R3: A write command (wr=1) raises the write strobe of the target module and drives the master's write data onto the bus. A read command (wr=0) raises the read strobe.
- R4: At most one strobe is high in any cycle, and a strobe is high only while some master holds the grant.
- R5: At most one grant is high at a time. A lone requester is granted on the clock edge after its request is seen with the bus idle, and its strobe rises on that same edge.
- R6: When both masters request in the same idle cycle, the grant goes to the master that was not granted last. Master 0 wins the first such tie after reset.
- R7: Only the acknowledge of the selected module ends a transfer. The other module's acknowledge has no effect, and the strobe stays high.
- R8: On the edge where the selected acknowledge is seen, the owning master's done bit pulses for one cycle with the error flag low. The read-data output then holds the selected module's read data for a read, and zero for a write.
- R9: The grant stays high during the done cycle and is released on the following edge.
- R10: If no valid acknowledge arrives, the strobe stays high for exactly 16 cycles. Done then pulses with the error flag high.
- R11: The bus write-data lines are zero whenever no write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | 2 | Bus request, one bit per master |
| m_wr | input | 2 | Command per master, 1 = write |
| m_addr | input | 16 | Address per master, master 0 in bits 7..0 |
| m_wdata | input | 16 | Write data per master, master 0 in bits 7..0 |
| m_gnt | output | 2 | Bus grant, one bit per master |
| m_done | output | 2 | Transfer finished pulse, one bit per master |
| m_err | output | 1 | Transfer ended by timeout (valid with done) |
| m_rdata | output | 8 | Returned read data (valid with done) |
| bus_off | output | 7 | Offset inside the selected module |
| bus_wdata | output | 8 | Shared write-data lines |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_ack | input | 1 | Memory transfer acknowledge |
| mem_rdata | input | 8 | Memory read data |
| io_ack | input | 1 | I/O transfer acknowledge |
| io_rdata | input | 8 | I/O read data |

## Verification
The grant, strobe, offset and write data are due one clock edge after a request meets an idle bus. Done, error and read data are due one edge after the selected acknowledge, and the grant falls one edge after that. The bench drives inputs and samples outputs on the falling edge, so each result is read exactly one rising edge after its cause. The timeout is measured by counting the falling edges at which the strobe is still high. The sweep covers every address with both commands, alternating masters, varied acknowledge delays and injected acknowledges from the wrong module.

// File: rtl/sysbus_pkg.sv
// Shared types for the system bus controller.
package sysbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_REL  = 2'd2
    } bus_state_t;

    typedef enum logic {
        TGT_MEM = 1'b0,
        TGT_IO  = 1'b1
    } bus_tgt_t;
endpackage

// File: rtl/sysbus_arb.sv
// Two-master round-robin picker.
// Assumes: pick is high only when at least one request is high.
// On a tie the master not granted last wins; a lone requester always wins.
module sysbus_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       pick,
    output logic       win
);
    logic last_q;

    // choose the winner from the current requests and the last owner
    always_comb begin
        if (req == 2'b11) win = ~last_q;
        else              win = req[1];
    end

    // remember who was granted last; reset favours master 0 on the first tie
    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= 1'b1;
        else if (pick) last_q <= win;
    end
endmodule

// File: rtl/sysbus_dec.sv
// Address split: top bit selects the module, the rest is the local offset.
// Assumes AW >= 2.
module sysbus_dec
    import sysbus_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    output bus_tgt_t      tgt,
    output logic [AW-2:0] off
);
    // module select from the high-order bit, offset from the remainder
    always_comb begin
        tgt = addr[AW-1] ? TGT_IO : TGT_MEM;
        off = addr[AW-2:0];
    end
endmodule

// File: rtl/sysbus_fsm.sv
// Transfer sequencer: idle -> transfer -> release.
// Ends a transfer on a hit or after TIMEOUT strobe cycles.
// Assumes start is only raised in the idle state.
module sysbus_fsm
    import sysbus_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       hit,
    output bus_state_t state,
    output logic       fin_ok,
    output logic       fin_to
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    // completion conditions of the transfer state
    always_comb begin
        fin_ok = (state == ST_XFER) && hit;
        fin_to = (state == ST_XFER) && !hit && (cnt_q == CNT_LAST);
    end

    // state register and strobe-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start) state <= ST_XFER;
                end
                ST_XFER: begin
                    if (fin_ok || fin_to) state <= ST_REL;
                    else                  cnt_q <= cnt_q + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sysbus_ctrl.sv
// Shared system bus controller: two masters, one memory and one I/O module.
// Grants the bus round-robin, latches the winner's command, decodes the
// address, drives one strobe, waits for the selected acknowledge or a
// timeout, returns done/error/read data, then releases the grant.
// Assumes masters hold their request until done.
module sysbus_ctrl
    import sysbus_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int TIMEOUT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      m_req,
    input  logic [1:0]      m_wr,
    input  logic [2*AW-1:0] m_addr,
    input  logic [2*DW-1:0] m_wdata,
    output logic [1:0]      m_gnt,
    output logic [1:0]      m_done,
    output logic            m_err,
    output logic [DW-1:0]   m_rdata,
    output logic [AW-2:0]   bus_off,
    output logic [DW-1:0]   bus_wdata,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            io_rd,
    output logic            io_wr,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            io_ack,
    input  logic [DW-1:0]   io_rdata
);
    localparam int NM = 2;

    logic [AW-1:0] addr_arr  [NM];
    logic [DW-1:0] wdata_arr [NM];

    // split the flat master buses into per-master lanes
    for (genvar g = 0; g < NM; g++) begin : g_lane
        assign addr_arr[g]  = m_addr[g*AW +: AW];
        assign wdata_arr[g] = m_wdata[g*DW +: DW];
    end

    bus_state_t    state;
    logic          win, grant_now, hit, fin_ok, fin_to;
    logic [1:0]    gnt_q, done_q;
    logic          wr_q, err_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    bus_tgt_t      tgt;
    logic [AW-2:0] off;

    assign grant_now = (state == ST_IDLE) && (m_req != 2'b00);

    sysbus_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (m_req),
        .pick  (grant_now),
        .win   (win)
    );

    sysbus_dec #(.AW(AW)) u_dec (
        .addr (addr_q),
        .tgt  (tgt),
        .off  (off)
    );

    sysbus_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (grant_now),
        .hit    (hit),
        .state  (state),
        .fin_ok (fin_ok),
        .fin_to (fin_to)
    );

    // only the addressed module's acknowledge counts
    assign hit = (tgt == TGT_MEM) ? mem_ack : io_ack;

    // grant, command latch and completion reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q   <= '0;
            done_q  <= '0;
            err_q   <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            done_q <= '0;
            if (grant_now) begin
                gnt_q   <= win ? 2'b10 : 2'b01;
                wr_q    <= m_wr[win];
                addr_q  <= addr_arr[win];
                wdata_q <= wdata_arr[win];
            end
            if (fin_ok || fin_to) begin
                done_q  <= gnt_q;
                err_q   <= fin_to;
                rdata_q <= (fin_ok && !wr_q)
                         ? ((tgt == TGT_MEM) ? mem_rdata : io_rdata) : '0;
            end
            if (state == ST_REL) gnt_q <= '0;
        end
    end

    // strobes and shared data lines follow the latched command
    always_comb begin
        mem_rd    = (state == ST_XFER) && (tgt == TGT_MEM) && !wr_q;
        mem_wr    = (state == ST_XFER) && (tgt == TGT_MEM) &&  wr_q;
        io_rd     = (state == ST_XFER) && (tgt == TGT_IO)  && !wr_q;
        io_wr     = (state == ST_XFER) && (tgt == TGT_IO)  &&  wr_q;
        bus_wdata = ((state == ST_XFER) && wr_q) ? wdata_q : '0;
        bus_off   = off;
    end

    assign m_gnt   = gnt_q;
    assign m_done  = done_q;
    assign m_err   = err_q;
    assign m_rdata = rdata_q;
endmodule

// File: rtl/sysbus_ctrl_chk.sv
// Protocol checker for sysbus_ctrl, attached by bind.
// Counts consecutive strobe cycles to bound the timeout window.
module sysbus_ctrl_chk #(
    parameter int DW      = 8,
    parameter int TIMEOUT = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    m_gnt,
    input logic [1:0]    m_done,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          io_rd,
    input logic          io_wr,
    input logic          mem_ack,
    input logic          io_ack,
    input logic [DW-1:0] bus_wdata
);
    logic [7:0] run_q;
    logic       any_strb;

    assign any_strb = mem_rd | mem_wr | io_rd | io_wr;

    // length of the current unbroken strobe run
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (any_strb) run_q <= run_q + 8'd1;
        else               run_q <= '0;
    end

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

    // R4
    strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_strb |-> (m_gnt != 2'b00));

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_gnt));

    // R7
    ack_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_ack && (mem_rd || mem_wr)) || (io_ack && (io_rd || io_wr)))
        |=> (m_done != 2'b00));

    // R9
    done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_done != 2'b00) |-> (m_gnt == m_done));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_done != 2'b00) |=> (m_gnt == 2'b00));

    // R10
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 8'(TIMEOUT));

    // R11
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr || io_wr) |-> (bus_wdata == '0));
endmodule

bind sysbus_ctrl sysbus_ctrl_chk #(.DW(DW), .TIMEOUT(TIMEOUT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_gnt     (m_gnt),
    .m_done    (m_done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .mem_ack   (mem_ack),
    .io_ack    (io_ack),
    .bus_wdata (bus_wdata)
);

// File: tb/sysbus_ctrl_tb.sv
module sysbus_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  m_req, m_wr;
    logic [15:0] m_addr, m_wdata;
    logic [1:0]  m_gnt, m_done;
    logic        m_err;
    logic [7:0]  m_rdata;
    logic [6:0]  bus_off;
    logic [7:0]  bus_wdata;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic        mem_ack, io_ack;
    logic [7:0]  mem_rdata, io_rdata;

    int checks = 0;
    int errors = 0;
    bit over   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysbus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_wr(m_wr),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_gnt(m_gnt), .m_done(m_done),
        .m_err(m_err), .m_rdata(m_rdata), .bus_off(bus_off),
        .bus_wdata(bus_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .io_ack(io_ack), .io_rdata(io_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {mem_rd, mem_wr, io_rd, io_wr};
    endfunction

    task automatic finish_run();
        if (!over) begin
            over = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_req = '0; m_wr = '0; m_addr = '0; m_wdata = '0;
        mem_ack = 1'b0; io_ack = 1'b0; mem_rdata = '0; io_rdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one full transfer from a lone requester
    task automatic xfer(input int m, input bit wr, input logic [7:0] addr,
                        input logic [7:0] wd, input int delay, input bit wrong);
        logic [7:0] rd;
        logic [3:0] exp_s;
        bit         isio;
        rd    = addr ^ 8'h5A;
        isio  = addr[7];
        exp_s = isio ? (wr ? 4'b0001 : 4'b0010) : (wr ? 4'b0100 : 4'b1000);
        m_req[m] = 1'b1;
        m_wr[m]  = wr;
        m_addr[m*8 +: 8]  = addr;
        m_wdata[m*8 +: 8] = wd;
        @(negedge clk);
        chk(m_gnt == (2'b01 << m), "R5 grant", m_gnt, 2'b01 << m);
        chk(strobes() == exp_s, "R2 R3 strobe", strobes(), exp_s);
        chk(bus_off == addr[6:0], "R2 offset", bus_off, addr[6:0]);
        chk(bus_wdata == (wr ? wd : 8'h00), "R3 R11 wdata", bus_wdata, wr ? wd : 8'h00);
        for (int i = 0; i < delay; i++) begin
            if (wrong) begin
                if (isio) mem_ack = 1'b1; else io_ack = 1'b1;
            end
            @(negedge clk);
            chk(m_done == 2'b00 && strobes() == exp_s, "R7 wait", {m_done, strobes()}, {2'b00, exp_s});
        end
        mem_ack = 1'b0; io_ack = 1'b0;
        if (isio) begin io_ack = 1'b1; io_rdata = rd; mem_rdata = ~rd; end
        else      begin mem_ack = 1'b1; mem_rdata = rd; io_rdata = ~rd; end
        @(negedge clk);
        chk(m_done == (2'b01 << m) && !m_err, "R8 done", {m_done, m_err}, {2'b01 << m, 1'b0});
        chk(m_rdata == (wr ? 8'h00 : rd), "R8 rdata", m_rdata, wr ? 8'h00 : rd);
        chk(m_gnt == (2'b01 << m) && strobes() == 4'b0, "R9 hold", {m_gnt, strobes()}, {2'b01 << m, 4'b0});
        mem_ack = 1'b0; io_ack = 1'b0;
        m_req[m] = 1'b0;
        @(negedge clk);
        chk(m_gnt == 2'b00 && m_done == 2'b00, "R9 release", {m_gnt, m_done}, 4'b0);
    endtask

    initial begin
        do_reset();
        chk(m_gnt == 2'b00 && strobes() == 4'b0 && m_done == 2'b00, "R1 reset", {m_gnt, strobes(), m_done}, 0);

        // sweep every address, both commands, alternating masters
        for (int a = 0; a < 256; a++) begin
            for (int w = 0; w < 2; w++) begin
                xfer(a % 2, w[0], 8'(a), 8'(a * 7 + 3), (a + w) % 3, (a % 5) == 0);
            end
        end

        // R10 timeout with no acknowledge
        begin
            int n;
            m_req[0] = 1'b1; m_wr[0] = 1'b0; m_addr[7:0] = 8'h10;
            @(negedge clk);
            n = 0;
            while (mem_rd && n < 40) begin
                n++;
                @(negedge clk);
            end
            chk(n == 16, "R10 window", n, 16);
            chk(m_done == 2'b01 && m_err, "R10 err", {m_done, m_err}, 3'b011);
            m_req[0] = 1'b0;
            @(negedge clk);
            chk(m_gnt == 2'b00, "R9 release after timeout", m_gnt, 0);
        end

        // R6 tie: both keep requesting; winners alternate from master 0
        do_reset();
        m_wr = 2'b00; m_addr = {8'h22, 8'h11};
        m_req = 2'b11;
        for (int k = 0; k < 4; k++) begin
            int guard;
            guard = 0;
            while (m_gnt == 2'b00 && guard < 6) begin
                @(negedge clk);
                guard++;
            end
            chk(m_gnt == ((k % 2) ? 2'b10 : 2'b01), "R6 tie winner", m_gnt, (k % 2) ? 2'b10 : 2'b01);
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            @(negedge clk);
            chk(m_gnt == 2'b00, "R9 tie release", m_gnt, 0);
        end
        m_req = 2'b00;

        // R1 reset during a transfer
        @(negedge clk);
        m_req[1] = 1'b1; m_wr[1] = 1'b1; m_addr[15:8] = 8'h90;
        @(negedge clk);
        chk(io_wr == 1'b1, "R3 io write", io_wr, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(m_gnt == 2'b00 && strobes() == 4'b0 && m_done == 2'b00, "R1 mid reset", {m_gnt, strobes(), m_done}, 0);
        m_req = 2'b00;
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end
endmodule